// File: doc/BRIEF.md
# Clock-Generator Configuration Register Slave (I2C Block Transfer)

This block is a serial slave on a two-wire I2C bus at standard-mode speed, 100 kbit/s or less. It holds seven 8-bit configuration bytes for a clock generator. A fast system clock samples SCL and SDA through two synchronizing flops and a short glitch filter. The block detects START and STOP, checks the device address, drives the acknowledge bit and moves bytes into or out of the register bank. All seven bytes leave the block on one flat output bus that feeds the clock control logic.

The register bank has no pointer. A write sends the device address, then two bytes that are acknowledged and thrown away, then data that always lands at byte 0 and goes up one byte at a time. The host may stop after any whole byte. A read sends back a byte count first and then every register in order. Bytes are carried MSB first. SDA is modelled as open drain: the block only ever pulls it low, through `sda_oe`.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset every register holds its fixed default. With default parameters, `cfg_o` = 0x81C33C5A00FF8F, where byte i sits at bits [8i+7:8i].
- R2: The block acknowledges (pulls SDA low in the ninth clock) the write address 0xD2 and the read address 0xD3. For any other address byte it gives no acknowledge and leaves SDA released until the next START.
- R3: In a write, the two bytes after the address are acknowledged and leave every register unchanged. The data bytes that follow are stored in byte 0, byte 1 and so on, in ascending order, and each one is acknowledged.
- R4: A write ended by STOP after k whole data bytes (k < 7) updates bytes 0..k-1 only. The other bytes keep their previous values.
- R5: Data bytes past byte 6 in a write are acknowledged and change no register.
- R6: A read returns the count byte 0x07, then bytes 0 to 6 in order, MSB first, with each bit valid while SCL is high.
- R7: If the host does not acknowledge a byte of a read, the block releases SDA and drives nothing until the next START.
- R8: A STOP or START seen in the middle of a byte aborts the transfer and discards that byte. After a START the block receives a fresh address byte.
- R9: A pulse on SCL that lasts two system-clock cycles or less is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset; loads the defaults |
| scl_i | input | 1 | Serial clock level seen at the pad |
| sda_i | input | 1 | Serial data level seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| cfg_o | output | 56 | Configuration bytes; byte i at bits [8i+7:8i] |

## Verification
A wrong internal state shows up at the pins within one bus bit. It appears as an acknowledge that is missing or misplaced, as a read bit that differs from the bank, or as a change on `cfg_o` after the ninth clock of the byte concerned. A byte counter that is off by one shifts every stored byte and every read byte by one position, so a full write followed by a read-back of distinct values finds it. A filter or edge detector that fails to reject a glitch adds a bit, which corrupts the data of the same byte.

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         NUM_REGS  = 7,
  parameter int         FILT      = 3,
  parameter logic [8*NUM_REGS-1:0] DEFAULTS = 56'h81C33C5A00FF8F
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [8*NUM_REGS-1:0] cfg_o
);
  localparam int CW = $clog2(NUM_REGS + 3) + 1;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXEND, S_ACKOUT, S_TX, S_ACKIN, S_ACKWAIT} st_t;

  logic [1:0]      scl_sy, sda_sy;
  logic [FILT-1:0] scl_h, sda_h;
  logic            scl_f, sda_f, scl_d, sda_d;
  st_t             st;
  logic [7:0]      sh, tx_byte;
  logic [2:0]      bitcnt;
  logic [CW-1:0]   cnt, widx, ridx;
  logic            rw, wr_hit;
  logic [8*NUM_REGS-1:0] cfg_q, cfg_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1; scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_h  <= {scl_h[FILT-2:0], scl_sy[1]};
      sda_h  <= {sda_h[FILT-2:0], sda_sy[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  wire start_c  = scl_f & scl_d & sda_d & ~sda_f;
  wire stop_c   = scl_f & scl_d & ~sda_d & sda_f;
  wire scl_rise = scl_f & ~scl_d;
  wire scl_fall = ~scl_f & scl_d;
  wire cnt_max  = &cnt;

  always_comb begin
    widx     = cnt - CW'(3);
    ridx     = cnt - CW'(2);
    wr_hit   = (cnt >= CW'(3)) && (widx < CW'(NUM_REGS));
    cfg_next = cfg_q;
    tx_byte  = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (widx == CW'(i)) cfg_next[8*i +: 8] = sh;
      if (cnt >= CW'(2) && ridx == CW'(i)) tx_byte = cfg_q[8*i +: 8];
    end
    if (cnt == CW'(1)) tx_byte = 8'(NUM_REGS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; bitcnt <= '0; cnt <= '0; rw <= 1'b0; cfg_q <= DEFAULTS;
    end else if (start_c) begin
      st <= S_RX; bitcnt <= '0; cnt <= '0; rw <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_RX: if (scl_rise) begin
          sh <= {sh[6:0], sda_f};
          if (bitcnt == 3'd7) st <= S_RXEND;
          else bitcnt <= bitcnt + 3'd1;
        end
        S_RXEND: if (scl_fall) begin
          if (cnt == '0) begin
            if (sh[7:1] == DEV_ADDR) begin rw <= sh[0]; st <= S_ACKOUT; end
            else st <= S_IDLE;
          end else begin
            st <= S_ACKOUT;
            if (!rw && wr_hit) cfg_q <= cfg_next;
          end
          if (!cnt_max) cnt <= cnt + CW'(1);
        end
        S_ACKOUT: if (scl_fall) begin
          bitcnt <= '0;
          if (rw) begin
            sh <= tx_byte; st <= S_TX;
            if (!cnt_max) cnt <= cnt + CW'(1);
          end else st <= S_RX;
        end
        S_TX: if (scl_fall) begin
          if (bitcnt == 3'd7) st <= S_ACKIN;
          else begin sh <= {sh[6:0], 1'b1}; bitcnt <= bitcnt + 3'd1; end
        end
        S_ACKIN: if (scl_rise) st <= sda_f ? S_IDLE : S_ACKWAIT;
        S_ACKWAIT: if (scl_fall) begin
          sh <= tx_byte; bitcnt <= '0; st <= S_TX;
          if (!cnt_max) cnt <= cnt + CW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sda_oe = (st == S_ACKOUT) | ((st == S_TX) & ~sh[7]);
  assign cfg_o  = cfg_q;

  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c && !start_c |=> st == S_IDLE);
  a_r8_start_readdr: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> st == S_RX && cnt == '0 && bitcnt == '0);
  a_r4_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    st != S_RXEND |=> $stable(cfg_o));
  a_r2_addr_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RXEND && scl_fall && !start_c && !stop_c && cnt == '0 && sh[7:1] != DEV_ADDR)
    |=> !sda_oe && st == S_IDLE);
  a_r7_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACKIN && scl_rise && sda_f && !start_c && !stop_c) |=> !sda_oe);
endmodule

// File: tb/sim_cfg_i2c_slave.sv
module sim_cfg_i2c_slave;
  localparam int Q = 10;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_h = 1'b1;
  logic sda_oe;
  logic [55:0] cfg_o;
  wire sda_line = sda_h & ~sda_oe;
  int n_chk = 0, n_bad = 0;
  logic [7:0] expb [0:6];
  logic mon_en = 1'b0, drv_seen = 1'b0;

  always #2 clk = ~clk;

  cfg_i2c_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
                    .sda_oe(sda_oe), .cfg_o(cfg_o));

  always @(negedge clk) if (mon_en && sda_oe) drv_seen = 1'b1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  function automatic logic [55:0] exp_all();
    logic [55:0] v;
    for (int i = 0; i < 7; i++) v[8*i +: 8] = expb[i];
    return v;
  endfunction

  task automatic i_start(); sda_h = 1; w(Q); scl = 1; w(2*Q); sda_h = 0; w(2*Q); scl = 0; endtask
  task automatic i_stop();  w(Q); sda_h = 0; w(Q); scl = 1; w(2*Q); sda_h = 1; w(2*Q); endtask

  task automatic put_bit(input logic b, input logic glitch);
    w(Q); sda_h = b;
    if (glitch) begin w(2); scl = 1; w(2); scl = 0; w(Q-4); end else w(Q);
    scl = 1; w(2*Q); scl = 0;
  endtask

  task automatic get_bit(output logic b);
    w(Q); sda_h = 1; w(Q); scl = 1; w(Q); b = sda_line; w(Q); scl = 0;
  endtask

  task automatic send(input logic [7:0] d, output logic ack, input logic glitch = 0);
    for (int i = 7; i >= 0; i--) put_bit(d[i], glitch);
    get_bit(ack);
  endtask

  task automatic recv(output logic [7:0] d, input logic host_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    w(Q); sda_h = host_ack ? 1'b0 : 1'b1; w(Q); scl = 1; w(2*Q); scl = 0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 7; i++) expb[i] = 56'h81C33C5A00FF8F >> (8*i);
    chk("R1 defaults", cfg_o, exp_all());
    chk("R1 sda released", sda_oe, 0);
  endtask

  task automatic t_write(input int n, input logic [7:0] base, input string req);
    logic a;
    i_start();
    send(8'hD2, a); chk("R2 write address ack", a, 0);
    send(8'hA5, a); chk("R3 command ack", a, 0);
    send(8'h3E, a); chk("R3 count ack", a, 0);
    chk("R3 dummies change nothing", cfg_o, exp_all());
    for (int i = 0; i < n; i++) begin
      send(base + 8'(i*17), a);
      chk({req, " data ack"}, a, 0);
      if (i < 7) expb[i] = base + 8'(i*17);
    end
    i_stop(); w(4*Q);
    chk(req, cfg_o, exp_all());
  endtask

  task automatic t_read();
    logic a; logic [7:0] d;
    i_start();
    send(8'hD3, a); chk("R2 read address ack", a, 0);
    recv(d, 1); chk("R6 count byte", d, 8'h07);
    for (int i = 0; i < 7; i++) begin
      recv(d, i != 6); chk("R6 read byte", d, expb[i]);
    end
    i_stop();
  endtask

  task automatic t_bad_addr();
    logic a; logic [7:0] d;
    i_start();
    drv_seen = 0; mon_en = 1;
    send(8'hA4, a); chk("R2 foreign address nack", a, 1);
    send(8'h00, a); send(8'h00, a);
    mon_en = 0;
    chk("R2 no drive after foreign address", drv_seen, 0);
    i_stop();
    chk("R2 regs untouched", cfg_o, exp_all());
    d = 0;
  endtask

  task automatic t_nack();
    logic a; logic [7:0] d;
    i_start();
    send(8'hD3, a); chk("R7 address ack", a, 0);
    recv(d, 0); chk("R7 count before nack", d, 8'h07);
    drv_seen = 0; mon_en = 1;
    recv(d, 1); recv(d, 1);
    mon_en = 0;
    chk("R7 released after nack", drv_seen, 0);
    chk("R7 reads all ones", d, 8'hFF);
    i_stop();
  endtask

  task automatic t_abort();
    logic a;
    i_start();
    send(8'hD2, a); send(8'h00, a); send(8'h00, a);
    send(8'h11, a); expb[0] = 8'h11;
    for (int i = 0; i < 4; i++) put_bit(1'b0, 0);
    i_stop(); w(4*Q);
    chk("R8 stop mid byte discards it", cfg_o, exp_all());
    i_start();
    send(8'hD2, a); send(8'h00, a);
    for (int i = 0; i < 3; i++) put_bit(1'b1, 0);
    i_start();
    send(8'hD2, a); chk("R8 fresh address after start", a, 0);
    send(8'h00, a); send(8'h00, a);
    send(8'h77, a); expb[0] = 8'h77;
    i_stop(); w(4*Q);
    chk("R8 write after restart", cfg_o, exp_all());
  endtask

  task automatic t_glitch();
    logic a;
    i_start();
    send(8'hD2, a, 1); chk("R9 address ack with glitches", a, 0);
    send(8'h00, a, 1); send(8'h00, a, 1);
    send(8'hC6, a, 1); expb[0] = 8'hC6;
    send(8'h39, a, 1); expb[1] = 8'h39;
    i_stop(); w(4*Q);
    chk("R9 glitched write stored", cfg_o, exp_all());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    w(5); rst_n = 1; w(5);
    t_reset();
    t_read();
    t_write(7, 8'h10, "R3 full write");
    t_read();
    t_write(3, 8'hE0, "R4 partial write");
    t_read();
    t_write(10, 8'h42, "R5 overlong write");
    t_read();
    t_bad_addr();
    t_nack();
    t_abort();
    t_glitch();
    t_read();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule